// File: doc/BRIEF.md
# Dual-Mode Compare-Match PWM Timer

This block is a single 16-bit up-counter with four compare registers (A, B, C, D) that drives four PWM pins. A prescaled count-enable tick advances the counter. Each compare register has a 3-bit action field. Bit 2 of the field is the pin's initial level. Bits [1:0] say what happens to the pin on a compare match: 00 keeps the level, 01 drives it low, 10 drives it high, and 11 toggles it. Any of the four registers can be chosen to clear the counter, and that register then sets the PWM period.

The block has two modes. In paired mode (mode bit 0), registers A and B both act on pin 0, and registers C and D both act on pin 2. One register of a pair sets the leading edge and the other sets the trailing edge. Pins 1 and 3 are held low in this mode. In period/duty mode (mode bit 1), the clear register is the period register and is tied to a pin that is held low. Each other register drives its own pin. When the period match clears the counter, every duty pin returns to its initial level. This gives edge-aligned PWM from 0% to 100% duty.

Writes to the counter, the compare registers, the action fields and the configuration (mode and clear select) take effect on the next clock edge. A configuration or action write also loads the initial levels onto the pins.

Top module: `pwm_cmp_timer`

## Requirements
- R1: After reset the counter, all compare registers and all action fields are zero, paired mode is selected with register A as the clear source, and all four pins are low. Ticking in this state leaves the pins low.
- R2: On an edge where the tick is low and nothing is written, the counter and all pins keep their values. A counter write loads the counter on that edge, and no compare match is taken in that cycle.
- R3: A compare match occurs on an edge where the tick is high and the counter equals a register. The pin is then updated on that same edge according to bits [1:0] of the register's field: 00 keep, 01 low, 10 high, 11 toggle.
- R4: On an edge where the selected clear register matches, the counter goes to zero. On any other ticked edge it increments. The period is therefore the register value plus one ticks.
- R5: In paired mode, pin 0 takes the actions of A and B, pin 2 takes the actions of C and D, and pins 1 and 3 are low.
- R6: In paired mode, the initial levels of pins 0 and 2 come from bit 2 of the fields of A and C. A counter clear does not change any pin.
- R7: In paired mode, if both registers of a pair hold the same value, matches leave that pair's pin unchanged.
- R8: In period/duty mode, each register other than the clear register drives its own pin (A to pin 0 through D to pin 3). The clear register's pin is low.
- R9: In period/duty mode, on the clearing match every duty pin is set to bit 2 of its own field.
- R10: In period/duty mode, a duty register equal to the period register never changes its pin from the initial level. An initial level of 1 gives 100% duty and an initial level of 0 gives 0% duty.
- R11: A configuration write or any action-field write loads, on that edge, the initial levels implied by the new mode, clear select and fields. This load takes priority over matches.
- R12: When the counter passes 16'hFFFF without a clear match, it wraps to zero and the pins are not reinitialised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Prescaled count enable |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | 16 | Counter write value |
| cmp_we | input | 4 | Per-register compare write strobes (bit 0 = A) |
| cmp_wdata | input | 16 | Compare write value |
| act_we | input | 4 | Per-register action-field write strobes (bit 0 = A) |
| act_wdata | input | 3 | Action field: [2] initial level, [1:0] match action |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 1 | 0 = paired mode, 1 = period/duty mode |
| cfg_clr_sel | input | 2 | Clear-source register (0 = A to 3 = D) |
| pwm_out | output | 4 | PWM pins |

## Verification
All state in this block shows up on the pins, but some of it only shows at particular counter values. The bench tracks the tick count and checks the pins on every ticked cycle. A wrong counter or a wrong clear decision therefore shifts an edge by the next match, which is within one period. A corrupted action field or initial level shows at the next match, clear or configuration write that uses it. A broken equality guard or a broken wrap path shows on the first cycle where that case occurs. The long case of a counter run past 16'hFFFF is reached by loading the counter close to the top.

// File: rtl/pwm_cmp_timer.sv
module pwm_cmp_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         cnt_we,
  input  logic [W-1:0] cnt_wdata,
  input  logic [3:0]   cmp_we,
  input  logic [W-1:0] cmp_wdata,
  input  logic [3:0]   act_we,
  input  logic [2:0]   act_wdata,
  input  logic         cfg_we,
  input  logic         cfg_mode,
  input  logic [1:0]   cfg_clr_sel,
  output logic [3:0]   pwm_out
);
  localparam int NREG = 4;

  logic [W-1:0] cnt;
  logic [W-1:0] cmp [NREG];
  logic [2:0]   act [NREG];
  logic         mode_q;
  logic [1:0]   sel_q;
  logic [3:0]   out_q, out_n;
  logic [3:0]   hit;
  logic [3:0]   ini_n;
  logic         clr_hit;
  logic         reinit;

  function automatic logic apply(input logic lv, input logic [1:0] a);
    case (a)
      2'b01:   return 1'b0;
      2'b10:   return 1'b1;
      2'b11:   return ~lv;
      default: return lv;
    endcase
  endfunction

  function automatic logic [3:0] init_vec(input logic m, input logic [1:0] s, input logic [3:0] ini);
    logic [3:0] v;
    if (!m) v = {1'b0, ini[2], 1'b0, ini[0]};
    else begin
      v = ini;
      v[s] = 1'b0;
    end
    return v;
  endfunction

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    assign hit[g]   = tick && !cnt_we && (cnt == cmp[g]);
    assign ini_n[g] = act_we[g] ? act_wdata[2] : act[g][2];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cmp[g] <= '0;
        act[g] <= '0;
      end else begin
        if (cmp_we[g]) cmp[g] <= cmp_wdata;
        if (act_we[g]) act[g] <= act_wdata;
      end
    end
  end

  assign clr_hit = hit[sel_q];
  assign reinit  = cfg_we || (act_we != '0);
  assign pwm_out = out_q;

  always_comb begin
    out_n = out_q;
    if (reinit) begin
      out_n = init_vec(cfg_we ? cfg_mode : mode_q, cfg_we ? cfg_clr_sel : sel_q, ini_n);
    end else if (!mode_q) begin
      if (cmp[0] != cmp[1]) begin
        if (hit[0]) out_n[0] = apply(out_q[0], act[0][1:0]);
        if (hit[1]) out_n[0] = apply(out_q[0], act[1][1:0]);
      end
      if (cmp[2] != cmp[3]) begin
        if (hit[2]) out_n[2] = apply(out_q[2], act[2][1:0]);
        if (hit[3]) out_n[2] = apply(out_q[2], act[3][1:0]);
      end
      out_n[1] = 1'b0;
      out_n[3] = 1'b0;
    end else if (clr_hit) begin
      out_n = init_vec(1'b1, sel_q, {act[3][2], act[2][2], act[1][2], act[0][2]});
    end else begin
      for (int i = 0; i < NREG; i++)
        if (hit[i] && (cmp[i] != cmp[sel_q])) out_n[i] = apply(out_q[i], act[i][1:0]);
      out_n[sel_q] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      mode_q <= 1'b0;
      sel_q  <= '0;
      out_q  <= '0;
    end else begin
      if (cnt_we)       cnt <= cnt_wdata;
      else if (clr_hit) cnt <= '0;
      else if (tick)    cnt <= cnt + 1'b1;
      if (cfg_we) begin
        mode_q <= cfg_mode;
        sel_q  <= cfg_clr_sel;
      end
      out_q <= out_n;
    end
  end

  p_reset_low_r1: assert property (@(posedge clk) !rst_n |-> (pwm_out == 4'b0000));

  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_we && !cfg_we && act_we == 4'b0000) |=> (cnt == $past(cnt) && pwm_out == $past(pwm_out)));

  p_clear_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit |=> (cnt == '0));

  p_pair_equal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && !cfg_we && act_we == 4'b0000 && cmp[0] == cmp[1]) |=> (pwm_out[0] == $past(pwm_out[0])));

  p_wrap_keep_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_we && &cnt && hit == 4'b0000 && !cfg_we && act_we == 4'b0000)
      |=> (cnt == '0 && pwm_out == $past(pwm_out)));

  for (genvar g = 0; g < NREG; g++) begin : g_chk
    p_restore_init_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q && clr_hit && !cfg_we && act_we == 4'b0000 && sel_q != 2'(g))
        |=> (pwm_out[g] == $past(act[g][2])));
  end
endmodule

// File: tb/pwm_cmp_timer_bench.sv
module pwm_cmp_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        cnt_we = 1'b0;
  logic [15:0] cnt_wdata = '0;
  logic [3:0]  cmp_we = '0;
  logic [15:0] cmp_wdata = '0;
  logic [3:0]  act_we = '0;
  logic [2:0]  act_wdata = '0;
  logic        cfg_we = 1'b0;
  logic        cfg_mode = 1'b0;
  logic [1:0]  cfg_clr_sel = '0;
  logic [3:0]  pwm_out;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  typedef struct { string req; logic [3:0] exp; } item_t;
  item_t sb[$];

  always #4 clk = ~clk;

  pwm_cmp_timer u_pwm_cmp_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
    .cmp_we(cmp_we), .cmp_wdata(cmp_wdata), .act_we(act_we), .act_wdata(act_wdata),
    .cfg_we(cfg_we), .cfg_mode(cfg_mode), .cfg_clr_sel(cfg_clr_sel), .pwm_out(pwm_out)
  );

  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (pwm_out !== it.exp) begin
        fails++;
        $display("FAIL %s: pwm_out actual %b expected %b", it.req, pwm_out, it.exp);
      end
    end
  end

  task automatic expect_pins(input string req, input logic [3:0] exp);
    item_t it;
    it.req = req;
    it.exp = exp;
    sb.push_back(it);
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr_cmp(input int i, input logic [15:0] v);
    cmp_we = 4'(1 << i); cmp_wdata = v; step(); cmp_we = '0;
  endtask

  task automatic wr_act(input int i, input logic [2:0] f);
    act_we = 4'(1 << i); act_wdata = f; step(); act_we = '0;
  endtask

  task automatic wr_cfg(input logic m, input logic [1:0] s);
    cfg_we = 1'b1; cfg_mode = m; cfg_clr_sel = s; step(); cfg_we = 1'b0;
  endtask

  task automatic wr_cnt(input logic [15:0] v);
    cnt_we = 1'b1; cnt_wdata = v; step(); cnt_we = 1'b0;
  endtask

  initial begin
    logic [15:0] c;
    logic [3:0]  e;
    logic        p0;
    #3;
    rst_n = 1'b1;
    step();
    expect_pins("R1", 4'b0000);
    tick = 1'b1;
    for (int k = 0; k < 5; k++) begin step(); expect_pins("R1", 4'b0000); end
    tick = 1'b0;

    // Period/duty mode, period register D = 9, A duty 3 (init 1, drive low), B keep (init 1)
    wr_cfg(1'b1, 2'd3);
    expect_pins("R11", 4'b0000);
    wr_act(0, 3'b101);
    expect_pins("R11", 4'b0001);
    wr_act(1, 3'b100);
    expect_pins("R11", 4'b0011);
    wr_act(3, 3'b111);
    expect_pins("R8", 4'b0011);
    wr_cmp(0, 16'd3);
    wr_cmp(3, 16'd9);
    wr_cmp(1, 16'd5);
    wr_cnt(16'd0);
    expect_pins("R2", 4'b0011);
    c = 0;
    tick = 1'b1;
    e = 4'b0011;
    for (int k = 0; k < 25; k++) begin
      step();
      c = (c == 16'd9) ? 16'd0 : c + 16'd1;
      e = {2'b00, 1'b1, (c <= 16'd3)};
      expect_pins((c == 0) ? "R9" : ((c == 4) ? "R4" : "R3"), e);
    end
    tick = 1'b0;
    for (int k = 0; k < 5; k++) begin step(); expect_pins("R2", e); end

    // Paired mode, clear on B; A=2 drive high, B=6 drive low; C=D=4
    wr_cfg(1'b0, 2'd1);
    expect_pins("R6", 4'b0001);
    wr_act(0, 3'b010);
    expect_pins("R6", 4'b0000);
    wr_act(1, 3'b001);
    wr_act(2, 3'b101);
    expect_pins("R6", 4'b0100);
    wr_act(3, 3'b101);
    wr_cmp(0, 16'd2);
    wr_cmp(1, 16'd6);
    wr_cmp(2, 16'd4);
    wr_cmp(3, 16'd4);
    wr_cnt(16'd0);
    expect_pins("R5", 4'b0100);
    c = 0;
    tick = 1'b1;
    for (int k = 0; k < 20; k++) begin
      step();
      c = (c == 16'd6) ? 16'd0 : c + 16'd1;
      expect_pins((c == 3) ? "R5" : ((c == 0) ? "R6" : "R7"),
                  {2'b01, 1'b0, (c >= 16'd3 && c <= 16'd6)});
    end
    tick = 1'b0;

    // Period/duty mode, period D = 5; A toggles at 16'hFFF8; B and C equal the period
    wr_cfg(1'b1, 2'd3);
    expect_pins("R11", 4'b0100);
    wr_act(0, 3'b011);
    wr_act(1, 3'b010);
    expect_pins("R10", 4'b0100);
    wr_cmp(3, 16'd5);
    wr_cmp(2, 16'd5);
    wr_cmp(1, 16'd5);
    wr_cmp(0, 16'hFFF8);
    wr_cnt(16'hFFF0);
    c = 16'hFFF0;
    p0 = 1'b0;
    tick = 1'b1;
    for (int k = 0; k < 35; k++) begin
      step();
      if (c == 16'd5) p0 = 1'b0;
      else if (c == 16'hFFF8) p0 = ~p0;
      c = (c == 16'd5) ? 16'd0 : c + 16'd1;
      expect_pins((c <= 16'd5 && p0) ? "R12" : ((c == 16'hFFF9) ? "R3" : "R10"),
                  {3'b010, p0});
    end
    tick = 1'b0;

    step();
    step();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule